// File: doc/BRIEF.md
# One-hot selected 8-bit ALU

This block is an arithmetic and logic unit with registered operands. It has two operand inputs, and each operand is held in a register that loads on the rising clock edge. A one-hot select word names one of nine fixed operations. The operations are an offset increment, shifts with a chosen fill value, an unsigned minimum, a rotation, a bit-order reversal, an exclusive-or, an offset sum and an all-ones constant. The result path after the operand registers is purely combinational, so the select word acts within the same cycle. The operands act one clock edge after they are presented.

The result is also split into nibbles. Each nibble drives the seven segments of one hexadecimal display digit. A controller outside this block supplies the select word, for example a counter followed by a decoder that steps through the nine operations. The operation data width, the operation constants and the segment polarity are parameters.

Top module: `alu_onehot8`

## Requirements
- R1: `a_in` and `b_in` are loaded into the operand registers on each rising edge of `clk`. A change on them reaches `result` only after the next rising edge. An active-low asynchronous `rst_n` clears both registers to 0.
- R2: Select bit k-1 chooses operation k, for k = 1..9. `result` is 0 when `sel` is all zeros, when any of bits 15..9 is set, or when more than one bit is set.
- R3: Operation 1 (sel bit 0) gives A + 2 modulo 256.
- R4: Operation 2 (sel bit 1) gives B shifted right by two places with zeros entering at the top. Operation 3 (sel bit 2) gives A shifted right by four places with ones entering at the top.
- R5: Operation 4 (sel bit 3) gives the smaller of A and B, compared as unsigned numbers.
- R6: Operation 5 (sel bit 4) gives A rotated right by two places.
- R7: Operation 6 (sel bit 5) gives B with its bit order reversed, so bit i moves to bit 7-i.
- R8: Operation 7 (sel bit 6) gives A XOR B.
- R9: Operation 8 (sel bit 7) gives A + B - 4 modulo 256.
- R10: Operation 9 (sel bit 8) gives 0xFF.
- R11: `seg_out[6:0]` shows `result[3:0]` and `seg_out[13:7]` shows `result[7:4]`. Within each 7-bit group, bit 0 is segment a and bit 6 is segment g, and a 1 lights the segment. The codes for digits 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of the operand registers |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| sel | input | 16 | One-hot operation select word |
| result | output | 8 | Operation result |
| seg_out | output | 14 | Segment drive for two hexadecimal digits, low nibble in bits 6:0 |

## Verification
Some operand pairs are needed to tell a faulty design from a correct one, and they are hard to hit by chance. An unsigned minimum only differs from a signed one when exactly one operand has its top bit set. The offset sum only shows its wrap when A + B is below 4, and the increment only shows its wrap when A is near 255. The vector table therefore lists these pairs on purpose. Directed steps then reach the select words that must yield zero, including two defined bits set together. A further step changes an operand between clock edges to show that the result waits for the register.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int NUM_OPS  = 9;
   localparam int SEG_BITS = 7;

   // operation positions in the one-hot select word
   localparam int OP_INC_A  = 0;
   localparam int OP_SHR_B  = 1;
   localparam int OP_SHR_A  = 2;
   localparam int OP_MIN    = 3;
   localparam int OP_ROR_A  = 4;
   localparam int OP_REV_B  = 5;
   localparam int OP_XOR    = 6;
   localparam int OP_SUMOFS = 7;
   localparam int OP_ONES   = 8;

   // hexadecimal digit to segments, bit 0 = a ... bit 6 = g, 1 = lit
   function automatic logic [SEG_BITS-1:0] hex_to_seg(input logic [3:0] nib);
      logic [SEG_BITS-1:0] s;
      case (nib)
         4'h0: s = 7'h3F;
         4'h1: s = 7'h06;
         4'h2: s = 7'h5B;
         4'h3: s = 7'h4F;
         4'h4: s = 7'h66;
         4'h5: s = 7'h6D;
         4'h6: s = 7'h7D;
         4'h7: s = 7'h07;
         4'h8: s = 7'h7F;
         4'h9: s = 7'h6F;
         4'hA: s = 7'h77;
         4'hB: s = 7'h7C;
         4'hC: s = 7'h39;
         4'hD: s = 7'h5E;
         4'hE: s = 7'h79;
         default: s = 7'h71;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/alu_operand_reg.sv
module alu_operand_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/alu_sel_decode.sv
module alu_sel_decode #(
   parameter int SEL_W = 16,
   parameter int N_OPS = 9
) (
   input  logic [SEL_W-1:0] sel,
   output logic [N_OPS-1:0] hit
);
   logic defined_onehot;
   logic stray;

   generate
      if (SEL_W > N_OPS) begin : g_upper
         assign stray = |sel[SEL_W-1:N_OPS];
      end else begin : g_exact
         assign stray = 1'b0;
      end
   endgenerate

   assign defined_onehot = $onehot(sel[N_OPS-1:0]);
   assign hit = (defined_onehot && !stray) ? sel[N_OPS-1:0] : '0;
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
   import alu_pkg::*;
#(
   parameter int W        = 8,
   parameter int INC_K    = 2,
   parameter int SHR_B_N  = 2,
   parameter int SHR_A_N  = 4,
   parameter int ROR_N    = 2,
   parameter int SUM_SUB  = 4
) (
   input  logic [W-1:0]       a,
   input  logic [W-1:0]       b,
   input  logic [NUM_OPS-1:0] hit,
   output logic [W-1:0]       y
);
   logic [W-1:0] res [NUM_OPS];
   logic [W-1:0] rev_b;
   logic [W-1:0] sum_ab;

   generate
      for (genvar i = 0; i < W; i++) begin : g_rev
         assign rev_b[i] = b[W-1-i];
      end
   endgenerate

   assign sum_ab = a + b;

   assign res[OP_INC_A]  = a + W'(INC_K);
   assign res[OP_SHR_B]  = b >> SHR_B_N;
   assign res[OP_SHR_A]  = (a >> SHR_A_N) | ~({W{1'b1}} >> SHR_A_N);
   assign res[OP_MIN]    = (a < b) ? a : b;
   assign res[OP_ROR_A]  = (a >> ROR_N) | (a << (W - ROR_N));
   assign res[OP_REV_B]  = rev_b;
   assign res[OP_XOR]    = a ^ b;
   assign res[OP_SUMOFS] = sum_ab - W'(SUM_SUB);
   assign res[OP_ONES]   = {W{1'b1}};

   // AND-OR selection: at most one hit bit is ever set
   always_comb begin
      y = '0;
      for (int k = 0; k < NUM_OPS; k++) begin
         y = y | (res[k] & {W{hit[k]}});
      end
   end
endmodule

// File: rtl/alu_hex_display.sv
module alu_hex_display
   import alu_pkg::*;
#(
   parameter int W          = 8,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic [W-1:0]               value,
   output logic [(W/4)*SEG_BITS-1:0]  seg
);
   localparam int NDIG = W / 4;

   generate
      for (genvar d = 0; d < NDIG; d++) begin : g_dig
         logic [SEG_BITS-1:0] lit;
         assign lit = hex_to_seg(value[d*4 +: 4]);
         if (ACTIVE_LOW) begin : g_low
            assign seg[d*SEG_BITS +: SEG_BITS] = ~lit;
         end else begin : g_high
            assign seg[d*SEG_BITS +: SEG_BITS] = lit;
         end
      end
   endgenerate
endmodule

// File: rtl/alu_onehot8.sv
module alu_onehot8
   import alu_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int SEL_W          = 16,
   parameter int INC_K          = 2,
   parameter int SHR_B_N        = 2,
   parameter int SHR_A_N        = 4,
   parameter int ROR_N          = 2,
   parameter int SUM_SUB        = 4,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [DATA_W-1:0]                  a_in,
   input  logic [DATA_W-1:0]                  b_in,
   input  logic [SEL_W-1:0]                   sel,
   output logic [DATA_W-1:0]                  result,
   output logic [(DATA_W/4)*SEG_BITS-1:0]     seg_out
);
   localparam int NDIG = DATA_W / 4;

   generate
      if (DATA_W % 4 != 0 || DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be a multiple of 4 and at least 8");
      end
      if (SEL_W < NUM_OPS) begin : g_bad_sel
         $error("SEL_W must cover all defined operations");
      end
      if (SHR_A_N >= DATA_W || SHR_B_N >= DATA_W || ROR_N <= 0 || ROR_N >= DATA_W) begin : g_bad_shift
         $error("shift and rotate distances must lie inside the data width");
      end
   endgenerate

   logic [DATA_W-1:0]  a_q;
   logic [DATA_W-1:0]  b_q;
   logic [NUM_OPS-1:0] hit;

   alu_operand_reg #(.W(DATA_W)) u_reg_a (
      .clk(clk), .rst_n(rst_n), .d(a_in), .q(a_q)
   );

   alu_operand_reg #(.W(DATA_W)) u_reg_b (
      .clk(clk), .rst_n(rst_n), .d(b_in), .q(b_q)
   );

   alu_sel_decode #(.SEL_W(SEL_W), .N_OPS(NUM_OPS)) u_dec (
      .sel(sel), .hit(hit)
   );

   alu_datapath #(
      .W(DATA_W), .INC_K(INC_K), .SHR_B_N(SHR_B_N), .SHR_A_N(SHR_A_N),
      .ROR_N(ROR_N), .SUM_SUB(SUM_SUB)
   ) u_dp (
      .a(a_q), .b(b_q), .hit(hit), .y(result)
   );

   alu_hex_display #(.W(DATA_W), .ACTIVE_LOW(SEG_ACTIVE_LOW)) u_disp (
      .value(result), .seg(seg_out)
   );
endmodule

// File: rtl/alu_onehot8_chk.sv
module alu_onehot8_chk #(
   parameter int DATA_W         = 8,
   parameter int SEL_W          = 16,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [DATA_W-1:0]             a_in,
   input logic [DATA_W-1:0]             b_in,
   input logic [SEL_W-1:0]              sel,
   input logic [DATA_W-1:0]             result,
   input logic [(DATA_W/4)*7-1:0]       seg_out,
   input logic [DATA_W-1:0]             a_q,
   input logic [DATA_W-1:0]             b_q
);
   localparam int NDIG = DATA_W / 4;
   localparam logic [6:0] ZERO_SEG = SEG_ACTIVE_LOW ? ~7'h3F : 7'h3F;

   logic bad_sel;
   assign bad_sel = !$onehot(sel[8:0]) || (|sel[SEL_W-1:9]);

   assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (a_q == $past(a_in)) && (b_q == $past(b_in)));

   assert_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bad_sel |-> result == '0);

   assert_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_W'(1 << 3)) |-> (result <= a_q) && (result <= b_q)
                                  && ((result == a_q) || (result == b_q)));

   assert_xor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_W'(1 << 6)) |-> ((result ^ b_q) == a_q));

   assert_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_W'(1 << 8)) |-> result == {DATA_W{1'b1}});

   assert_seg_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (result == '0) |-> seg_out == {NDIG{ZERO_SEG}});
endmodule

bind alu_onehot8 alu_onehot8_chk #(
   .DATA_W(DATA_W), .SEL_W(SEL_W), .SEG_ACTIVE_LOW(SEG_ACTIVE_LOW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .sel(sel),
   .result(result), .seg_out(seg_out), .a_q(a_q), .b_q(b_q)
);

// File: tb/test_alu_onehot8.sv
module test_alu_onehot8;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  a_in = 8'h00;
   logic [7:0]  b_in = 8'h00;
   logic [15:0] sel = 16'h0000;
   logic [7:0]  result;
   logic [13:0] seg_out;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   alu_onehot8 i_alu_onehot8 (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .sel(sel),
      .result(result), .seg_out(seg_out)
   );

   // vector layout {A, B, op, expected}; op 1..9 selects sel bit op-1
   localparam int NVEC = 23;
   localparam logic [27:0] VEC [NVEC] = '{
      28'h3CA513E, 28'h3CA5229, 28'h3CA53F3, 28'h3CA543C, 28'h3CA550F,
      28'h3CA56A5, 28'h3CA5799, 28'h3CA58DD, 28'h3CA59FF,
      28'hFE01100, 28'hFE01200, 28'hFE013FF, 28'hFE01401, 28'hFE015BF,
      28'hFE01680, 28'hFE018FB,
      28'h01023F0, 28'h0102401, 28'h0102540, 28'h0102640, 28'h01028FF,
      28'h807F47F, 28'hFF0F7F0
   };

   function automatic logic [6:0] seg_ref(input logic [3:0] n);
      logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                             7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
      return t[n];
   endfunction

   function automatic string req_of(input int op);
      case (op)
         1: return "R3";
         2, 3: return "R4";
         4: return "R5";
         5: return "R6";
         6: return "R7";
         7: return "R8";
         8: return "R9";
         9: return "R10";
         default: return "R2";
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_seg(input logic [7:0] v);
      check("R11", 16'(seg_out), 16'({seg_ref(v[7:4]), seg_ref(v[3:0])}));
   endtask

   // drive after a falling edge, sample 1 ns after the rising edge
   task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [15:0] s);
      @(negedge clk);
      a_in = a; b_in = b; sel = s;
      @(posedge clk);
      #1;
   endtask

   initial begin
      // reset state: registers cleared, R1
      a_in = 8'h55; b_in = 8'hAA; sel = 16'h0040;
      repeat (2) @(posedge clk);
      #1;
      check("R1", 16'(result), 16'h00);
      sel = 16'h0001;
      #1;
      check("R1", 16'(result), 16'h02);
      check_seg(8'h02);
      @(negedge clk);
      rst_n = 1'b1;

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         logic [7:0] va, vb, ve;
         int op;
         va = VEC[i][27:20];
         vb = VEC[i][19:12];
         op = int'(VEC[i][11:8]);
         ve = VEC[i][7:0];
         apply(va, vb, (op == 0) ? 16'h0000 : (16'h0001 << (op - 1)));
         check(req_of(op), 16'(result), 16'(ve));
         check_seg(ve);
      end

      // R2: select words that must give zero
      apply(8'h3C, 8'hA5, 16'h0000);
      check("R2", 16'(result), 16'h00);
      check_seg(8'h00);
      apply(8'h3C, 8'hA5, 16'h0200);
      check("R2", 16'(result), 16'h00);
      apply(8'h3C, 8'hA5, 16'h0201);
      check("R2", 16'(result), 16'h00);
      apply(8'h3C, 8'hA5, 16'h0003);
      check("R2", 16'(result), 16'h00);
      apply(8'h3C, 8'hA5, 16'h8000);
      check("R2", 16'(result), 16'h00);
      apply(8'h3C, 8'hA5, 16'h0100);
      check("R10", 16'(result), 16'hFF);

      // R1: operand change between edges is not seen until the next edge
      apply(8'h10, 8'h00, 16'h0040);
      check("R1", 16'(result), 16'h10);
      #2 a_in = 8'h20;
      #1;
      check("R1", 16'(result), 16'h10);
      @(posedge clk);
      #1;
      check("R1", 16'(result), 16'h20);

      // R1: asynchronous clear between edges
      #2 rst_n = 1'b0;
      #1;
      check("R1", 16'(result), 16'h00);
      @(negedge clk);
      rst_n = 1'b1;

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule